// File: doc/BRIEF.md
# Timer Clock-Enable Source Selector

This block decides when a timer counter may advance. It never gates or generates a clock. It produces a single-cycle enable pulse, `tick`, in the system clock domain. A 3-bit select input chooses where the pulses come from:

- no source at all, which holds the timer still;
- every system clock cycle;
- one of four taps of a shared, free-running power-of-two divider;
- an edge of an asynchronous external pin, either rising or falling.

The pin is brought into the clock domain by a chain of flip-flops. An edge detector then turns each qualified transition into exactly one pulse.

The divider is a free-running binary counter that starts from zero at reset. Its width is set by a parameter and defaults to 10 bits. A divider tap is active in every cycle where the counter's low bits for that ratio are all zero. The ratios are 8, 64, 256 and 1024. The counter keeps running through select changes, so several timers could share one divider and stay in phase. The `tick` output is combinational from registered state and the select input, so a change of select takes effect in the same cycle.

Top module: `tick_source_select`

## Requirements
- R1: With select code 3'b000 the tick output stays low in every cycle.
- R2: With select code 3'b001 the tick output is high in every cycle while out of reset.
- R3: Select codes 3'b010, 3'b011, 3'b100 and 3'b101 give divide ratios of 8, 64, 256 and 1024. The tick is high exactly in those cycles where the number of clock edges since reset release, modulo 1024, is a multiple of the ratio.
- R4: With select code 3'b111, a low-to-high change of the external pin gives a tick that is high for exactly one cycle. That cycle directly follows the second rising clock edge after the change.
- R5: With select code 3'b110, a high-to-low change of the external pin gives a single one-cycle tick, with the same latency as R4.
- R6: Each pin transition of the selected polarity gives exactly one tick. A pin held at a constant level gives no further ticks.
- R7: Changing the select field never restarts the divider. The divider phase after any sequence of select changes equals the count of clock edges since reset.
- R8: While reset is asserted (active low) the tick output is low. In the first cycle after release the divider count is zero, so a divider tap is active at once.
- R9: While an external-pin code is selected, pin transitions of the other polarity produce no tick. While a divider code is selected, pin activity does not disturb the tick pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 3 | Tick source select code |
| ext_pin | input | 1 | Asynchronous external count input |
| tick | output | 1 | One-cycle count enable for the timer counter |

## Verification
Two things can happen in the same cycle: a change of select and a divider tap becoming active. The bench provokes this by waiting until its own edge count is one short of a multiple of 64, then switching from divide-by-8 to divide-by-64 on the falling clock edge just before the tap cycle. It expects a tick in that very cycle and the normal 64-cycle spacing afterwards. The bench also switches the pin source while an edge is in flight or held. Ticks are judged purely from the requirement formulas, using a bench-side count of clock edges since reset.

// File: rtl/tick_sel_pkg.sv
package tick_sel_pkg;

   typedef enum logic [2:0] {
      SRC_OFF      = 3'd0,
      SRC_SYS      = 3'd1,
      SRC_DIV_A    = 3'd2,
      SRC_DIV_B    = 3'd3,
      SRC_DIV_C    = 3'd4,
      SRC_DIV_D    = 3'd5,
      SRC_PIN_FALL = 3'd6,
      SRC_PIN_RISE = 3'd7
   } src_sel_e;

   localparam int unsigned NUM_TAPS = 4;

endpackage

// File: rtl/tsel_pin_edge.sv
module tsel_pin_edge #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_async,
   output logic rise_pulse,
   output logic fall_pulse
);

   localparam int unsigned CHAIN_LEN = SYNC_STAGES + 1;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("tsel_pin_edge: SYNC_STAGES must be at least 2");
   end

   logic [CHAIN_LEN-1:0] chain_q;

   for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_chain
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= pin_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   logic sync_now;
   logic sync_prev;
   assign sync_now   = chain_q[SYNC_STAGES-1];
   assign sync_prev  = chain_q[SYNC_STAGES];
   assign rise_pulse = sync_now & ~sync_prev;
   assign fall_pulse = ~sync_now & sync_prev;

   assert_rise_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rise_pulse |=> !rise_pulse);
   assert_fall_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fall_pulse |=> !fall_pulse);
   assert_no_dual_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_pulse && fall_pulse));
   assert_rise_settles_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rise_pulse |=> sync_prev);

endmodule

// File: rtl/tsel_divider.sv
module tsel_divider
   import tick_sel_pkg::*;
#(
   parameter int unsigned DIV_W   = 10,
   parameter int unsigned SHIFT_A = 3,
   parameter int unsigned SHIFT_B = 6,
   parameter int unsigned SHIFT_C = 8,
   parameter int unsigned SHIFT_D = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   output logic [NUM_TAPS-1:0] tap
);

   localparam int unsigned SHIFTS [NUM_TAPS] = '{SHIFT_A, SHIFT_B, SHIFT_C, SHIFT_D};

   if (SHIFT_D > DIV_W) begin : g_bad_width
      $error("tsel_divider: largest tap exceeds divider width");
   end
   if (!(SHIFT_A >= 1 && SHIFT_A < SHIFT_B && SHIFT_B < SHIFT_C && SHIFT_C < SHIFT_D)) begin : g_bad_order
      $error("tsel_divider: tap shifts must be strictly increasing and nonzero");
   end

   logic [DIV_W-1:0] div_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) div_cnt <= '0;
      else        div_cnt <= div_cnt + 1'b1;
   end

   for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
      localparam logic [DIV_W-1:0] LOW_MASK = DIV_W'((64'd1 << SHIFTS[t]) - 64'd1);
      assign tap[t] = ((div_cnt & LOW_MASK) == '0);

      assert_tap_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
         tap[t] |=> !tap[t]);
      if (t > 0) begin : g_nest
         assert_tap_nested_R3: assert property (@(posedge clk) disable iff (!rst_n)
            tap[t] |-> tap[t-1]);
      end
   end

endmodule

// File: rtl/tick_source_select.sv
module tick_source_select
   import tick_sel_pkg::*;
#(
   parameter int unsigned DIV_W       = 10,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned SHIFT_A     = 3,
   parameter int unsigned SHIFT_B     = 6,
   parameter int unsigned SHIFT_C     = 8,
   parameter int unsigned SHIFT_D     = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] sel,
   input  logic       ext_pin,
   output logic       tick
);

   logic [NUM_TAPS-1:0] tap;
   logic                pin_rise;
   logic                pin_fall;
   logic                src_tick;
   src_sel_e            sel_e;

   tsel_divider #(
      .DIV_W   (DIV_W),
      .SHIFT_A (SHIFT_A),
      .SHIFT_B (SHIFT_B),
      .SHIFT_C (SHIFT_C),
      .SHIFT_D (SHIFT_D)
   ) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .tap   (tap)
   );

   tsel_pin_edge #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_pin (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_async  (ext_pin),
      .rise_pulse (pin_rise),
      .fall_pulse (pin_fall)
   );

   assign sel_e = src_sel_e'(sel);

   always_comb begin
      unique case (sel_e)
         SRC_OFF:      src_tick = 1'b0;
         SRC_SYS:      src_tick = 1'b1;
         SRC_DIV_A:    src_tick = tap[0];
         SRC_DIV_B:    src_tick = tap[1];
         SRC_DIV_C:    src_tick = tap[2];
         SRC_DIV_D:    src_tick = tap[3];
         SRC_PIN_FALL: src_tick = pin_fall;
         SRC_PIN_RISE: src_tick = pin_rise;
         default:      src_tick = 1'b0;
      endcase
   end

   assign tick = rst_n & src_tick;

   assert_reset_quiet_R8: assert property (@(posedge clk)
      !rst_n |-> !tick);
   assert_pin_tick_spaced_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && sel[2] && sel[1] && $stable(sel)) |=> !(tick && $stable(sel)));
   assert_div_tick_tap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && sel_e == SRC_DIV_D) |-> tap[0]);

endmodule

// File: tb/tb_tick_source_select.sv
module tb_tick_source_select;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] sel = 3'd0;
   logic       ext_pin = 1'b0;
   logic       tick;

   int checks   = 0;
   int failures = 0;
   int edges    = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   tick_source_select dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (sel),
      .ext_pin (ext_pin),
      .tick    (tick)
   );

   // bench-side count of clock edges since reset release
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) edges <= 0;
      else        edges <= edges + 1;
   end

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s t=%0t tick=%b expected=%b edges=%0d", req, $time, act, exp, edges);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic drive_sel(input logic [2:0] s);
      @(negedge clk);
      sel = s;
   endtask

   task automatic drive_pin(input logic v);
      @(negedge clk);
      ext_pin = v;
   endtask

   function automatic logic div_expect(input int ratio);
      return ((edges % 1024) % ratio) == 0;
   endfunction

   task automatic t_reset();
      @(negedge clk);
      rst_n = 1'b0;
      sel   = 3'b001;
      #1;
      check("R8 tick low in reset", tick, 1'b0);
      step();
      check("R8 tick low in reset after edge", tick, 1'b0);
      @(negedge clk);
      sel   = 3'b101;
      rst_n = 1'b1;
      #1;
      check("R8 divider at zero after release", tick, 1'b1);
      step();
      check("R8 no tick one edge after release", tick, 1'b0);
   endtask

   task automatic t_stop();
      drive_sel(3'b000);
      for (int i = 0; i < 40; i++) begin
         step();
         check("R1 stopped", tick, 1'b0);
      end
   endtask

   task automatic t_sys();
      drive_sel(3'b001);
      for (int i = 0; i < 20; i++) begin
         step();
         check("R2 every cycle", tick, 1'b1);
      end
   endtask

   task automatic t_div(input logic [2:0] code, input int ratio, input int cycles);
      drive_sel(code);
      for (int i = 0; i < cycles; i++) begin
         step();
         check($sformatf("R3 divide by %0d", ratio), tick, div_expect(ratio));
      end
   endtask

   task automatic t_switch_on_tap();
      drive_sel(3'b010);
      do step(); while ((edges % 64) != 63);
      @(negedge clk);
      sel = 3'b011;
      step();
      check("R7 tap in switch cycle", tick, 1'b1);
      for (int i = 0; i < 130; i++) begin
         step();
         check("R7 phase kept after switch", tick, div_expect(64));
      end
      drive_sel(3'b000);
      repeat (37) step();
      drive_sel(3'b100);
      for (int i = 0; i < 600; i++) begin
         step();
         check("R7 phase kept across stop", tick, div_expect(256));
      end
   endtask

   task automatic t_rise();
      drive_sel(3'b111);
      ext_pin = 1'b0;
      repeat (4) step();
      drive_pin(1'b1);
      step();
      check("R4 no tick after first edge", tick, 1'b0);
      step();
      check("R4 tick after second edge", tick, 1'b1);
      step();
      check("R4 single cycle tick", tick, 1'b0);
      for (int i = 0; i < 10; i++) begin
         step();
         check("R6 held high gives no tick", tick, 1'b0);
      end
   endtask

   task automatic t_fall();
      drive_sel(3'b110);
      repeat (3) step();
      check("R6 select change with held pin", tick, 1'b0);
      drive_pin(1'b0);
      step();
      check("R5 no tick after first edge", tick, 1'b0);
      step();
      check("R5 tick after second edge", tick, 1'b1);
      step();
      check("R5 single cycle tick", tick, 1'b0);
   endtask

   task automatic t_toggle_count();
      int seen;
      drive_sel(3'b111);
      repeat (4) step();
      seen = 0;
      for (int k = 0; k < 5; k++) begin
         drive_pin(1'b1);
         step(); if (tick) seen++;
         drive_pin(1'b0);
         step(); if (tick) seen++;
         step(); if (tick) seen++;
      end
      repeat (4) begin step(); if (tick) seen++; end
      checks++;
      if (seen != 5) begin
         failures++;
         $display("FAIL R6 rising edge count actual=%0d expected=5", seen);
      end
   endtask

   task automatic t_ignore();
      drive_sel(3'b111);
      ext_pin = 1'b0;
      drive_pin(1'b1);
      repeat (4) step();
      drive_pin(1'b0);
      for (int i = 0; i < 5; i++) begin
         step();
         check("R9 falling edge ignored in rise mode", tick, 1'b0);
      end
      drive_sel(3'b010);
      for (int i = 0; i < 48; i++) begin
         @(negedge clk);
         ext_pin = ~ext_pin;
         step();
         check("R9 pin activity ignored in divide mode", tick, div_expect(8));
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      t_stop();
      t_sys();
      t_div(3'b010, 8, 40);
      t_div(3'b011, 64, 200);
      t_div(3'b100, 256, 600);
      t_div(3'b101, 1024, 2100);
      t_switch_on_tap();
      t_rise();
      t_fall();
      t_toggle_count();
      t_ignore();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule